// File: doc/BRIEF.md
# Serial SAR Converter Read Controller

This block sits on the host side of a 12-bit successive-approximation converter with a three-wire serial link. It drives the converter's active-low select line, which doubles as its shutdown control. It also drives an idle-high serial clock, divided down from the system clock, and it captures the converter's serial data output. Each conversion opens with a falling edge on the select line. The first data bit that comes back is a null bit and is thrown away. The twelve result bits follow, most significant first. The controller samples each bit on the rising serial clock edge, which is the edge opposite the one the converter uses to change its output.

After reset the controller waits out a power-up settling period of `SETTLE_US` microseconds, counted in system clocks derived from `SYS_CLK_HZ`. It then runs one full frame on its own to prime the converter's track-and-hold, and discards the data from that frame. From then on a one-cycle start request begins a conversion. A request for N bits, with N from 1 to 11, gives a short frame of N+1 serial clocks. A short frame ends early and saves power, at the cost of a lower-resolution result. Any other request gives a full 16-clock frame. Each result appears on a parallel port with a one-cycle valid strobe and the count of bits that are valid. Between frames the select line stays high for a minimum acquisition gap.

Top module: `sar_rd_ctrl`

## Requirements
- R1: Reset state: select high, serial clock high, busy high, ready low and valid low. After reset is released the select line stays high for exactly SETTLE_US*SYS_CLK_HZ/1e6 system clocks.
- R2: After the settling wait, exactly one full frame of 16 serial clocks runs and produces no valid strobe. The ready output rises only after that frame and its acquisition gap, and no valid strobe appears while ready is low.
- R3: Every frame begins with the select line falling. The serial clock idles high and falls only while the select line is low. A full frame has 16 falling edges.
- R4: The bit sampled at the first rising edge (the null bit) is discarded. The bits sampled at rising edges 2 through 13 are placed into result bits 11 down to 0 in that order. Bits sampled after rising edge 13 are discarded.
- R5: A request code N from 1 to 11 on `nbits_i` gives a frame of N+1 serial clocks. The N captured bits are placed at the top of the 12-bit result, the 12-N low bits are zero, and `res_nbits_o` reports N.
- R6: Request codes 0, 12, 13, 14 and 15 all give a full 16-clock frame with a 12-bit result, and `res_nbits_o` reports 12.
- R7: `res_valid_o` is high for one cycle, in the first cycle with the select line high again after a data frame. `res_data_o` and `res_nbits_o` change only in that cycle.
- R8: Between frames the select line stays high for at least CS_GAP system clocks. When a start request is held high, the gap is exactly CS_GAP+1 clocks.
- R9: A start request is ignored during the settling wait, the dummy frame, any frame in progress and the acquisition gap. It causes no extra frame.
- R10: `busy_o` is low only when the controller is idle with the select line high, and it is high from the cycle a frame starts.
- R11: Each serial clock half period lasts SCLK_DIV system clocks. The select line stays low for (2*clocks+1)*SCLK_DIV system clocks per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| nbits_i | input | 4 | Requested resolution: 1..11 gives a short frame, any other value gives a full frame |
| busy_o | output | 1 | Controller is not idle |
| ready_o | output | 1 | Power-up sequence complete |
| res_valid_o | output | 1 | One-cycle strobe for a new result |
| res_data_o | output | 12 | Result, left-aligned, unreceived bits zero |
| res_nbits_o | output | 4 | Number of valid bits in res_data_o |
| adc_cs_n_o | output | 1 | Active-low select and shutdown line to the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter, idle high |
| adc_dout_i | input | 1 | Serial data from the converter |

## Verification
The checker watches every cycle. It confirms that the serial clock stays idle high and still while the select line is high, that no result appears before ready, and that each valid strobe falls on the rising select edge. It also checks that the result only changes on that strobe, that the reported bit count stays in range, and that the bits below that count are zero. Other properties are beyond it and only the bench's scenarios can show them. The bench sweeps every request code against several data words and a walking-one pattern, using a behavioural converter that sends a null bit of one and junk after the result. That sweep shows the bit ordering, the discarded null and trailing bits, and the exact lengths of the settling wait, the frame and the gap. It also covers the single dummy frame and the rejection of requests made while busy.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    localparam int RES_W      = 12;
    localparam int FRAME_FULL = 16;
    localparam int NB_W       = 4;
    localparam int CNT_W      = 5;

    typedef enum logic [1:0] {
        ST_SETTLE,
        ST_IDLE,
        ST_FRAME,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic [NB_W-1:0]  nbits;
    } sar_result_t;

    // Map any request code to a legal resolution: 1..11 stays, others mean full.
    function automatic logic [NB_W-1:0] clamp_bits(input logic [NB_W-1:0] req);
        if (req == '0 || req > NB_W'(RES_W))
            return NB_W'(RES_W);
        return req;
    endfunction

    // Serial clocks needed for a resolution: null bit plus data, full frame at 12.
    function automatic logic [CNT_W-1:0] frame_clks(input logic [NB_W-1:0] nb);
        if (nb == NB_W'(RES_W))
            return CNT_W'(FRAME_FULL);
        return CNT_W'(nb) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/sar_rd_tick.sv
module sar_rd_tick #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
    import sar_rd_pkg::*;
#(
    parameter int SETTLE_CYCLES = 250000,
    parameter int CS_GAP        = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NB_W-1:0]  nbits_i,
    input  logic             tick_i,
    output logic             run_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             sample_o,
    output logic [CNT_W-1:0] sample_idx_o,
    output logic             frame_start_o,
    output logic             frame_done_o,
    output logic             dummy_o,
    output logic             busy_o,
    output logic             ready_o,
    output logic [NB_W-1:0]  nbits_o
);
    localparam int WAIT_MAX = (SETTLE_CYCLES > CS_GAP) ? SETTLE_CYCLES : CS_GAP;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam logic [WAIT_W-1:0] SETTLE_LAST = WAIT_W'(SETTLE_CYCLES - 1);
    localparam logic [WAIT_W-1:0] GAP_LAST    = WAIT_W'(CS_GAP - 1);

    seq_state_e       state_q;
    logic [WAIT_W-1:0] wait_q;
    logic [CNT_W-1:0] edges_q;
    logic             sclk_q;
    logic             cs_n_q;
    logic             dummy_q;
    logic             ready_q;
    logic [NB_W-1:0]  nb_q;

    logic in_frame;
    logic last_edge;
    logic settle_end;
    logic user_start;

    assign in_frame   = (state_q == ST_FRAME);
    assign last_edge  = (edges_q == frame_clks(nb_q));
    assign settle_end = (state_q == ST_SETTLE) && (wait_q == SETTLE_LAST);
    assign user_start = (state_q == ST_IDLE) && start_i;

    assign frame_start_o = settle_end || user_start;
    assign sample_o      = in_frame && tick_i && !sclk_q;
    assign frame_done_o  = in_frame && tick_i && sclk_q && last_edge;
    assign sample_idx_o  = edges_q + CNT_W'(1);
    assign run_o         = in_frame;
    assign cs_n_o        = cs_n_q;
    assign sclk_o        = sclk_q;
    assign dummy_o       = dummy_q;
    assign busy_o        = (state_q != ST_IDLE);
    assign ready_o       = ready_q;
    assign nbits_o       = nb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SETTLE;
            wait_q  <= '0;
            edges_q <= '0;
            sclk_q  <= 1'b1;
            cs_n_q  <= 1'b1;
            dummy_q <= 1'b0;
            ready_q <= 1'b0;
            nb_q    <= NB_W'(RES_W);
        end else begin
            unique case (state_q)
                ST_SETTLE: begin
                    if (settle_end) begin
                        state_q <= ST_FRAME;
                        cs_n_q  <= 1'b0;
                        dummy_q <= 1'b1;
                        nb_q    <= NB_W'(RES_W);
                        edges_q <= '0;
                    end else begin
                        wait_q <= wait_q + WAIT_W'(1);
                    end
                end
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_FRAME;
                        cs_n_q  <= 1'b0;
                        dummy_q <= 1'b0;
                        nb_q    <= clamp_bits(nbits_i);
                        edges_q <= '0;
                    end
                end
                ST_FRAME: begin
                    if (tick_i) begin
                        if (sclk_q) begin
                            if (last_edge) begin
                                cs_n_q  <= 1'b1;
                                state_q <= ST_GAP;
                                wait_q  <= '0;
                            end else begin
                                sclk_q <= 1'b0;
                            end
                        end else begin
                            sclk_q  <= 1'b1;
                            edges_q <= edges_q + CNT_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (wait_q == GAP_LAST) begin
                        state_q <= ST_IDLE;
                        ready_q <= 1'b1;
                        dummy_q <= 1'b0;
                    end else begin
                        wait_q <= wait_q + WAIT_W'(1);
                    end
                end
                default: state_q <= ST_SETTLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture
    import sar_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start_i,
    input  logic             sample_i,
    input  logic [CNT_W-1:0] sample_idx_i,
    input  logic             dout_i,
    input  logic             frame_done_i,
    input  logic             dummy_i,
    input  logic [NB_W-1:0]  nbits_i,
    output logic             valid_o,
    output sar_result_t      res_o
);
    logic [RES_W-1:0] shift_q;

    // Result bit b takes the sample from rising edge RES_W+1-b; edge 1 is the null bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else if (frame_start_i) begin
            shift_q <= '0;
        end else if (sample_i) begin
            for (int b = 0; b < RES_W; b++) begin
                if (sample_idx_i == CNT_W'(RES_W + 1 - b))
                    shift_q[b] <= dout_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            res_o   <= '0;
        end else begin
            valid_o <= frame_done_i && !dummy_i;
            if (frame_done_i && !dummy_i) begin
                res_o.data  <= shift_q;
                res_o.nbits <= nbits_i;
            end
        end
    end
endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
    import sar_rd_pkg::*;
#(
    parameter int SYS_CLK_HZ = 100_000_000,
    parameter int SETTLE_US  = 2500,
    parameter int SCLK_DIV   = 16,
    parameter int CS_GAP     = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NB_W-1:0]  nbits_i,
    output logic             busy_o,
    output logic             ready_o,
    output logic             res_valid_o,
    output logic [RES_W-1:0] res_data_o,
    output logic [NB_W-1:0]  res_nbits_o,
    output logic             adc_cs_n_o,
    output logic             adc_sclk_o,
    input  logic             adc_dout_i
);
    localparam int SETTLE_RAW    = (SYS_CLK_HZ / 1_000_000) * SETTLE_US;
    localparam int SETTLE_CYCLES = (SETTLE_RAW > 0) ? SETTLE_RAW : 1;

    logic             run;
    logic             tick;
    logic             sample;
    logic [CNT_W-1:0] sample_idx;
    logic             frame_start;
    logic             frame_done;
    logic             dummy;
    logic [NB_W-1:0]  frame_nbits;
    sar_result_t      result;

    sar_rd_tick #(.DIV(SCLK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .tick_o (tick)
    );

    sar_rd_seq #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .CS_GAP        (CS_GAP)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .nbits_i       (nbits_i),
        .tick_i        (tick),
        .run_o         (run),
        .cs_n_o        (adc_cs_n_o),
        .sclk_o        (adc_sclk_o),
        .sample_o      (sample),
        .sample_idx_o  (sample_idx),
        .frame_start_o (frame_start),
        .frame_done_o  (frame_done),
        .dummy_o       (dummy),
        .busy_o        (busy_o),
        .ready_o       (ready_o),
        .nbits_o       (frame_nbits)
    );

    sar_rd_capture u_cap (
        .clk           (clk),
        .rst           (rst),
        .frame_start_i (frame_start),
        .sample_i      (sample),
        .sample_idx_i  (sample_idx),
        .dout_i        (adc_dout_i),
        .frame_done_i  (frame_done),
        .dummy_i       (dummy),
        .nbits_i       (frame_nbits),
        .valid_o       (res_valid_o),
        .res_o         (result)
    );

    assign res_data_o  = result.data;
    assign res_nbits_o = result.nbits;
endmodule

// File: rtl/sar_rd_checker.sv
module sar_rd_checker
    import sar_rd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy_o,
    input logic             ready_o,
    input logic             res_valid_o,
    input logic [RES_W-1:0] res_data_o,
    input logic [NB_W-1:0]  res_nbits_o,
    input logic             adc_cs_n_o,
    input logic             adc_sclk_o
);
    // R3: the serial clock is parked high whenever the select line is high
    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n_o |-> adc_sclk_o);

    // R3: the serial clock moves only inside a frame
    assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(adc_sclk_o) |-> !adc_cs_n_o);

    // R2: nothing is delivered before the power-up sequence ends
    assert_no_early_result_R2: assert property (@(posedge clk) disable iff (rst)
        !ready_o |-> !res_valid_o);

    // R7: the strobe coincides with the select line rising
    assert_valid_at_cs_rise_R7: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $rose(adc_cs_n_o));

    // R7: the result holds between strobes
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !res_valid_o |-> ($stable(res_data_o) && $stable(res_nbits_o)));

    // R5: the reported width is legal
    assert_nbits_range_R5: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (res_nbits_o != '0 && res_nbits_o <= NB_W'(RES_W)));

    // R5: bits below the reported width are zero
    assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> ((res_data_o & ({RES_W{1'b1}} >> res_nbits_o)) == '0));

    // R10: an idle controller keeps the converter deselected
    assert_idle_deselected_R10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> adc_cs_n_o);
endmodule

bind sar_rd_ctrl sar_rd_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .ready_o     (ready_o),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_data_o),
    .res_nbits_o (res_nbits_o),
    .adc_cs_n_o  (adc_cs_n_o),
    .adc_sclk_o  (adc_sclk_o)
);

// File: tb/sar_rd_ctrl_bench.sv
module sar_rd_ctrl_bench;
    localparam int DIV    = 2;
    localparam int GAP    = 4;
    localparam int SETTLE = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  nb_req = 4'd0;
    logic        busy, ready, valid, cs_n, sclk;
    logic [11:0] data;
    logic [3:0]  nbits;
    logic        dout = 1'b1;
    logic [11:0] word_m = 12'h000;

    always #4 clk = ~clk;

    sar_rd_ctrl #(
        .SYS_CLK_HZ (1_000_000),
        .SETTLE_US  (SETTLE),
        .SCLK_DIV   (DIV),
        .CS_GAP     (GAP)
    ) u_sar_rd_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .nbits_i     (nb_req),
        .busy_o      (busy),
        .ready_o     (ready),
        .res_valid_o (valid),
        .res_data_o  (data),
        .res_nbits_o (nbits),
        .adc_cs_n_o  (cs_n),
        .adc_sclk_o  (sclk),
        .adc_dout_i  (dout)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Converter model: null bit (driven as 1) on fall 1, result MSB first on falls 2..13, junk ones after.
    int fidx = 0;
    always @(negedge cs_n) begin
        fidx = 0;
        dout = 1'b1;
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            fidx++;
            if (fidx >= 2 && fidx <= 13) dout = word_m[13 - fidx];
            else                         dout = 1'b1;
        end
    end

    // Port monitor
    int frames = 0, valids = 0, falls = 0, low_len = 0, high_len = 0;
    int last_falls = 0, last_low = 0, min_gap = 1000000;
    bit track_gap = 0;
    bit prev_cs = 1'b1, prev_sclk = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_cs && !cs_n) begin
                frames++;
                if (track_gap && high_len < min_gap) min_gap = high_len;
                falls = 0;
                low_len = 0;
            end
            if (!cs_n) low_len++;
            if (prev_sclk && !sclk && !cs_n) falls++;
            if (!prev_cs && cs_n) begin
                last_falls = falls;
                last_low = low_len;
                high_len = 0;
            end
            if (cs_n) high_len++;
            if (valid) begin
                valids++;
                check(cs_n && !prev_cs, "R7 strobe on select rise", int'(cs_n), 1);
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic do_frame(input logic [3:0] req, input logic [11:0] w, input bit poke);
        int n, nclk, v0, f0, t;
        logic [11:0] exp;
        n    = (req == 0 || req > 12) ? 12 : int'(req);
        nclk = (n == 12) ? 16 : n + 1;
        exp  = w & (12'hFFF << (12 - n));
        v0 = valids;
        f0 = frames;
        word_m = w;
        @(negedge clk);
        start = 1'b1;
        nb_req = req;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy in frame", int'(busy), 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            nb_req = 4'd3;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!valid && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (n == 12) begin
            check(data == exp, "R4/R6 full result", int'(data), int'(exp));
            check(nbits == 4'd12, "R6 width full", int'(nbits), 12);
        end else begin
            check(data == exp, "R5 short result", int'(data), int'(exp));
            check(nbits == 4'(n), "R5 width short", int'(nbits), n);
        end
        @(negedge clk);
        check(last_falls == nclk, "R3 falling edge count", last_falls, nclk);
        check(last_low == (2 * nclk + 1) * DIV, "R11 select low length", last_low, (2 * nclk + 1) * DIV);
        repeat (GAP + 6) @(negedge clk);
        check(frames - f0 == 1, "R9 one frame per request", frames - f0, 1);
        check(valids - v0 == 1, "R7 one strobe per frame", valids - v0, 1);
        check(busy == 1'b0 && cs_n == 1'b1, "R10 idle after gap", int'(busy), 0);
    endtask

    localparam logic [11:0] WORDS [4] = '{12'hFFF, 12'h000, 12'hA5C, 12'h3B6};

    initial begin
        int n, t;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b1, "R1 reset pins", int'({cs_n, sclk}), 3);
        check(busy == 1'b1 && ready == 1'b0 && valid == 1'b0, "R1 reset flags",
              int'({busy, ready, valid}), 4);
        rst = 1'b0;
        n = 0;
        while (cs_n && n < 10000) begin
            start = (n < 20);
            nb_req = 4'd2;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(n == SETTLE, "R1 settle length", n, SETTLE);
        check(ready == 1'b0, "R2 not ready in dummy", int'(ready), 0);
        t = 0;
        while (!ready && t < 2000) begin
            start = (t < 30);
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        check(ready == 1'b1, "R2 ready after dummy", int'(ready), 1);
        check(frames == 1, "R2/R9 single dummy frame", frames, 1);
        check(valids == 0, "R2 dummy discarded", valids, 0);
        check(last_falls == 16, "R2 dummy is full frame", last_falls, 16);
        repeat (3) @(negedge clk);
        check(frames == 1 && busy == 1'b0, "R9 no frame from early requests", frames, 1);

        for (int r = 0; r < 16; r++) begin
            for (int k = 0; k < 4; k++) begin
                do_frame(4'(r), WORDS[k], (k == 2));
            end
        end
        for (int b = 0; b < 12; b++) begin
            do_frame(4'd12, 12'(1 << b), 1'b0);
        end

        // R8: back-to-back frames with start held high
        min_gap = 1000000;
        track_gap = 1'b1;
        word_m = 12'h777;
        @(negedge clk);
        n = valids;
        start = 1'b1;
        nb_req = 4'd4;
        t = 0;
        while (valids - n < 3 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        track_gap = 1'b0;
        check(min_gap == GAP + 1, "R8 select gap", min_gap, GAP + 1);
        check(data == 12'h700, "R5 back-to-back result", int'(data), 12'h700);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule